// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave

This block is the slave side of a two-wire serial memory bus. It runs on a fast system clock. It oversamples the bus clock and data lines and finds START and STOP events. It takes in the device byte and checks it against a fixed type code and a set of strap pins. It then answers by pulling the data line low. Bytes are written into an internal byte-wide register file, and bytes from that file are shifted back out for reads.

One address pointer serves reads and writes, and it survives between transfers. This pointer gives the following operations:
- byte write and page write, where the address rolls over inside the page;
- current-address read;
- random read, which is a dummy write followed by a repeated START;
- sequential read, which runs through the whole array and wraps to zero.

Write-commit logic outside the block receives a one-cycle pulse after a STOP that ends a write. While that logic holds its busy input, the slave refuses every device byte. A host can therefore poll for completion by repeating the device byte until the slave acknowledges it.

Top module: `tws_mem_slave`

## Requirements
- R1: Nothing is recognised until a START (data line falling while the clock line is high). Bytes clocked in without a START get no acknowledge. A STOP (data line rising while the clock line is high) returns the engine to idle with the line released.
- R2: The device byte is accepted only if bits 7:4 equal 1010. The strap-compared middle bits must also equal their strap inputs. With the default 512-byte array, device bits 3:2 are compared with strap_i[2:1]. Any mismatch leaves the line released in the ninth clock.
- R3: In the ninth clock the slave pulls the data line low for each accepted device byte, each word-address byte and each written data byte.
- R4: A byte write stores the data byte at the address formed by the block bits and the word-address byte. The array is written only while the clock line is low.
- R5: During a page write, only the low PAGE_W address bits advance after each data byte, with PAGE_W = 3 giving 8-byte pages. Writing more bytes than one page holds rolls over to the page start and overwrites earlier bytes.
- R6: A read that is not preceded by a word address returns the byte at the stored pointer, which is the last accessed address plus one. The pointer wraps from the top of the array to 0.
- R7: A write of only a word address, followed by a repeated START and a read device byte, returns the byte at that word address.
- R8: In a read, the slave sends the next byte after every master acknowledge and crosses page borders. After a master non-acknowledge it releases the line.
- R9: While busy_i is high, the slave gives no acknowledge to its own device byte.
- R10: The slave only ever pulls the data line low, through sda_oe. sda_oe never goes high while the clock line is high.
- R11: With the default array size, device-byte bit 1 is the block bit and forms memory address bit 8.
- R12: commit_o pulses for one cycle after a STOP that ends a transfer in which at least one data byte was written. Reads and address-only writes give no pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8 times the bus clock rate |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| strap_i | input | 3 | Pin-strapped device address bits |
| busy_i | input | 1 | High while the write-commit logic is programming |
| sda_oe | output | 1 | When high, the pad pulls the data line low |
| commit_o | output | 1 | One-cycle pulse asking for a write commit |

## Verification
The assertions assume a well-behaved master:
- it changes the data line only while the clock line is low, except to form START and STOP;
- each clock phase lasts several system clocks;
- it never drives against the slave's pull-down.

The bench keeps to these rules. Each bus phase is a quarter period of ten system clocks. The master drive is wired-AND with the slave's pull-down, and the master always releases the line during the acknowledge bits and the read bits. busy_i changes only while the bus is idle after a STOP.

// File: rtl/tws_pkg.sv
package tws_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_RX,
    S_RXACK,
    S_TX,
    S_TXACK
  } eng_st_e;

  typedef enum logic [1:0] {
    K_DEV,
    K_WADR,
    K_DATA
  } rx_kind_e;

  localparam logic [3:0] DEV_TYPE = 4'b1010;
endpackage

// File: rtl/tws_sync.sv
module tws_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_sh, sda_sh;
  logic              scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[STAGES-2:0], scl_i};
      sda_sh <= {sda_sh[STAGES-2:0], sda_i};
      scl_d  <= scl_sh[STAGES-1];
      sda_d  <= sda_sh[STAGES-1];
    end
  end

  assign scl_s     = scl_sh[STAGES-1];
  assign sda_s     = sda_sh[STAGES-1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/tws_regfile.sv
module tws_regfile #(
  parameter int AW = 9
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  localparam int DEPTH = 1 << AW;

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/tws_mem_slave.sv
module tws_mem_slave
  import tws_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int PAGE_W = 3,
  parameter int SYNC_W = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] strap_i,
  input  logic       busy_i,
  output logic       sda_oe,
  output logic       commit_o
);
  localparam int BLK_BITS = (ADDR_W > 8) ? ADDR_W - 8 : 0;
  localparam int BLKW     = (BLK_BITS > 0) ? BLK_BITS : 1;
  localparam logic [2:0] STRAP_MASK = 3'(3'b111 << BLK_BITS);
  localparam logic [ADDR_W-1:0] ONE  = 1;
  localparam logic [PAGE_W-1:0] PONE = 1;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sh;
  logic       rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sh <= 2'b00;
    else        rst_sh <= {rst_sh[0], 1'b1};
  end
  assign rst_i = rst_sh[1];

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  tws_sync #(.STAGES(SYNC_W)) u_sync (
    .clk(clk), .rst_n(rst_i), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  eng_st_e           st_q, st_n;
  rx_kind_e          kind_q, kind_n;
  logic [3:0]        cnt_q, cnt_n;
  logic [7:0]        shr_q, shr_n, txr_q, txr_n;
  logic [ADDR_W-1:0] ptr_q, ptr_n, word_full, ptr_page_inc;
  logic [BLKW-1:0]   blk_q, blk_n;
  logic              rw_q, rw_n, more_q, more_n, wrote_q, wrote_n;
  logic              commit_q, commit_n, mem_we, byte_end, dev_hit;
  logic [7:0]        mem_rdata;

  tws_regfile #(.AW(ADDR_W)) u_mem (
    .clk(clk), .we(mem_we), .waddr(ptr_q), .wdata(shr_q),
    .raddr(ptr_q), .rdata(mem_rdata)
  );

  // block-select bits from the device byte form the top of the word address
  if (BLK_BITS > 0) begin : g_blk
    assign word_full = {blk_q, shr_q};
  end else begin : g_noblk
    assign word_full = shr_q[ADDR_W-1:0];
  end

  assign ptr_page_inc = {ptr_q[ADDR_W-1:PAGE_W], ptr_q[PAGE_W-1:0] + PONE};
  assign byte_end     = scl_fall && (cnt_q == 4'd8);
  assign dev_hit      = (shr_q[7:4] == DEV_TYPE) &&
                        (((shr_q[3:1] ^ strap_i) & STRAP_MASK) == 3'b000) && !busy_i;

  always_comb begin
    st_n = st_q;   kind_n = kind_q; cnt_n = cnt_q;  shr_n = shr_q;
    txr_n = txr_q; ptr_n = ptr_q;   blk_n = blk_q;  rw_n = rw_q;
    more_n = more_q; wrote_n = wrote_q; commit_n = 1'b0; mem_we = 1'b0;
    if (stop_det) begin
      st_n     = S_IDLE;
      commit_n = wrote_q;
      wrote_n  = 1'b0;
    end else if (start_det) begin
      st_n   = S_RX;
      kind_n = K_DEV;
      cnt_n  = 4'd0;
    end else begin
      case (st_q)
        S_RX: begin
          if (scl_rise) begin
            shr_n = {shr_q[6:0], sda_s};
            cnt_n = cnt_q + 4'd1;
          end else if (byte_end) begin
            cnt_n = 4'd0;
            st_n  = S_RXACK;
            case (kind_q)
              K_DEV: begin
                if (dev_hit) begin
                  rw_n   = shr_q[0];
                  blk_n  = shr_q[BLKW:1];
                  kind_n = K_WADR;
                end else begin
                  st_n = S_IDLE;
                end
              end
              K_WADR: begin
                ptr_n  = word_full;
                kind_n = K_DATA;
              end
              default: begin
                mem_we  = 1'b1;
                ptr_n   = ptr_page_inc;
                wrote_n = 1'b1;
              end
            endcase
          end
        end
        S_RXACK: begin
          if (scl_fall) begin
            if (rw_q) begin
              st_n  = S_TX;
              txr_n = mem_rdata;
              ptr_n = ptr_q + ONE;
            end else begin
              st_n = S_RX;
            end
          end
        end
        S_TX: begin
          if (scl_fall) begin
            if (cnt_q == 4'd7) begin
              st_n  = S_TXACK;
              cnt_n = 4'd0;
            end else begin
              txr_n = {txr_q[6:0], 1'b0};
              cnt_n = cnt_q + 4'd1;
            end
          end
        end
        S_TXACK: begin
          if (scl_rise) begin
            more_n = !sda_s;
          end else if (scl_fall) begin
            if (more_q) begin
              st_n  = S_TX;
              txr_n = mem_rdata;
              ptr_n = ptr_q + ONE;
            end else begin
              st_n = S_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      st_q <= S_IDLE;  kind_q <= K_DEV; cnt_q <= '0;   shr_q <= '0;
      txr_q <= '0;     ptr_q <= '0;     blk_q <= '0;   rw_q <= 1'b0;
      more_q <= 1'b0;  wrote_q <= 1'b0; commit_q <= 1'b0;
    end else begin
      st_q <= st_n;    kind_q <= kind_n; cnt_q <= cnt_n; shr_q <= shr_n;
      txr_q <= txr_n;  ptr_q <= ptr_n;   blk_q <= blk_n; rw_q <= rw_n;
      more_q <= more_n; wrote_q <= wrote_n; commit_q <= commit_n;
    end
  end

  assign sda_oe   = (st_q == S_RXACK) || ((st_q == S_TX) && !txr_q[7]);
  assign commit_o = commit_q;

  AST_OE_RISE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_i)
    $rose(sda_oe) |-> !scl_s); // R10
  AST_BUSY_NO_ACK: assert property (@(posedge clk) disable iff (!rst_i)
    (st_q == S_RX && kind_q == K_DEV && byte_end && busy_i && !start_det && !stop_det)
      |=> !sda_oe); // R9
  AST_STOP_IDLES: assert property (@(posedge clk) disable iff (!rst_i)
    stop_det |=> (st_q == S_IDLE && !sda_oe)); // R1
  AST_COMMIT_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_i)
    commit_o |-> $past(stop_det)); // R12
  AST_WE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_i)
    mem_we |-> !scl_s); // R4
endmodule

// File: tb/tb_tws_mem_slave.sv
`timescale 1ns/1ps
module tb_tws_mem_slave;
  localparam int Q = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic [2:0] strap = 3'b101;
  logic busy = 1'b0;
  logic sda_oe, commit;
  logic sda_line;
  int checks = 0, errors = 0, commits = 0, viol = 0;
  logic oe_prev;

  always #2.5 clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;

  tws_mem_slave dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .strap_i(strap), .busy_i(busy), .sda_oe(sda_oe), .commit_o(commit)
  );

  always @(posedge clk) begin
    if (commit) commits++;
    if (rst_n && scl_m && (sda_oe !== oe_prev)) viol++;
    oe_prev <= sda_oe;
  end

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic q();
    repeat (Q) @(posedge clk);
    #1;
  endtask

  task automatic bus_start();
    sda_m = 1'b1; q(); scl_m = 1'b1; q(); sda_m = 1'b0; q(); scl_m = 1'b0; q();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; q(); scl_m = 1'b1; q(); sda_m = 1'b1; q();
  endtask

  task automatic tx_bit(input logic b);
    sda_m = b; q(); scl_m = 1'b1; q(); q(); scl_m = 1'b0; q();
  endtask

  task automatic rx_bit(output logic b);
    sda_m = 1'b1; q(); scl_m = 1'b1; q(); b = sda_line; q(); scl_m = 1'b0; q();
  endtask

  task automatic send_byte(input logic [7:0] d, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) tx_bit(d[i]);
    rx_bit(b);
    ack = !b;
  endtask

  task automatic recv_byte(output logic [7:0] d, input logic mack);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      rx_bit(b);
      d[i] = b;
    end
    tx_bit(!mack);
  endtask

  function automatic logic [7:0] dev(input logic blk, input logic rd);
    return {4'b1010, 2'b10, blk, rd};
  endfunction

  task automatic do_write(input logic blk, input logic [7:0] word, input logic [7:0] first,
                          input int n, input string tag);
    logic ack;
    bus_start();
    send_byte(dev(blk, 1'b0), ack); chk(ack, {tag, " R2 device ack"}, ack, 1);
    send_byte(word, ack);           chk(ack, {tag, " R3 word ack"}, ack, 1);
    for (int i = 0; i < n; i++) begin
      send_byte(first + 8'(i), ack); chk(ack, {tag, " R3 data ack"}, ack, 1);
    end
    bus_stop(); q();
  endtask

  task automatic rand_read(input logic blk, input logic [7:0] word, input int n,
                           input logic [31:0] exp, input string tag);
    logic ack;
    logic [7:0] d;
    bus_start();
    send_byte(dev(blk, 1'b0), ack); chk(ack, {tag, " R7 dummy device ack"}, ack, 1);
    send_byte(word, ack);           chk(ack, {tag, " R7 dummy word ack"}, ack, 1);
    bus_start();
    send_byte(dev(blk, 1'b1), ack); chk(ack, {tag, " R7 read device ack"}, ack, 1);
    for (int i = 0; i < n; i++) begin
      recv_byte(d, i < n - 1);
      chk(d == exp[8*i +: 8], {tag, " data"}, d, exp[8*i +: 8]);
    end
    chk(sda_oe == 1'b0, {tag, " R8 released after nack"}, sda_oe, 0);
    bus_stop(); q();
  endtask

  task automatic cur_read(input logic [7:0] exp, input string tag);
    logic ack;
    logic [7:0] d;
    bus_start();
    send_byte(dev(1'b0, 1'b1), ack); chk(ack, {tag, " device ack"}, ack, 1);
    recv_byte(d, 1'b0);
    chk(d == exp, tag, d, exp);
    bus_stop(); q();
  endtask

  task automatic t_reset();
    chk(sda_oe == 1'b0, "R1 line released after reset", sda_oe, 0);
    chk(commit == 1'b0, "R12 no commit after reset", commit, 0);
  endtask

  task automatic t_no_start();
    logic ack;
    scl_m = 1'b0; q();
    send_byte(dev(1'b0, 1'b0), ack);
    chk(!ack, "R1 no ack without START", ack, 0);
    bus_stop(); q();
  endtask

  task automatic t_mismatch();
    logic ack;
    bus_start(); send_byte(8'hB8, ack); chk(!ack, "R2 wrong type code", ack, 0); bus_stop(); q();
    bus_start(); send_byte(8'hA0, ack); chk(!ack, "R2 wrong strap bits", ack, 0); bus_stop(); q();
  endtask

  task automatic t_busy();
    logic ack;
    busy = 1'b1;
    bus_start(); send_byte(dev(1'b0, 1'b0), ack); chk(!ack, "R9 no ack while busy", ack, 0);
    bus_stop(); q();
    busy = 1'b0;
    bus_start(); send_byte(dev(1'b0, 1'b0), ack); chk(ack, "R9 ack once idle", ack, 1);
    bus_stop(); q();
    chk(commits == 5, "R12 no commit for address-only poll", commits, 5);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog R1 actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (10) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (5) @(posedge clk);
    #1;
    t_reset();
    t_no_start();
    do_write(1'b0, 8'h12, 8'h5A, 1, "R4 byte write");
    chk(commits == 1, "R12 commit after byte write", commits, 1);
    do_write(1'b1, 8'h3C, 8'h10, 6, "R5 page write");
    chk(commits == 2, "R12 commit after page write", commits, 2);
    do_write(1'b0, 8'h3C, 8'h77, 1, "R11 block0 write");
    rand_read(1'b0, 8'h12, 1, 32'h0000_005A, "R4 R7 random read");
    chk(commits == 3, "R12 no commit for reads", commits, 3);
    rand_read(1'b1, 8'h38, 2, 32'h0000_1514, "R5 page rollover");
    rand_read(1'b1, 8'h3C, 4, 32'h1312_1110, "R8 sequential read");
    rand_read(1'b0, 8'h3C, 1, 32'h0000_0077, "R11 block bit");
    rand_read(1'b1, 8'h3E, 1, 32'h0000_0012, "R6 setup");
    cur_read(8'h13, "R6 current address read");
    do_write(1'b1, 8'hFF, 8'hC3, 1, "R6 top write");
    do_write(1'b0, 8'h00, 8'h3C, 1, "R6 bottom write");
    chk(commits == 5, "R12 commit count", commits, 5);
    rand_read(1'b1, 8'hFF, 2, 32'h0000_3CC3, "R6 R8 wrap");
    rand_read(1'b1, 8'hFF, 1, 32'h0000_00C3, "R6 wrap setup");
    cur_read(8'h3C, "R6 current read wraps to 0");
    t_mismatch();
    t_busy();
    chk(viol == 0, "R10 sda_oe moved while SCL high", viol, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule